// File: doc/BRIEF.md
# Store Handshake and Autostore Controller

This controller decides when the SRAM contents are copied into the nonvolatile array, and it announces that copy on a shared open-drain handshake line. A store can start in two ways. In autostore, the supply sinks through the switch threshold. An explicit request pulse can also start one. In both cases the controller enables its pull-down on the handshake line for a fixed window. After a settle delay it samples the line through a two-flop synchronizer. If the line is still high, something outside is holding it up. The store is then vetoed: the pull-down is released and a one-cycle abort pulse is raised. If the line went low, a one-cycle store-start pulse goes to the array copy engine. Busy then stays high until the engine reports completion.

An inhibit strap turns off the supply-decay trigger, so that stores come only from explicit requests. While the supply-below-switch flag is high, explicit requests are ignored. Each falling crossing of the supply gives at most one autostore attempt. The trigger rearms only after the flag has gone low again.

Top module: `store_handshake_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pull_en_o, store_start_o, abort_o and busy_o are all low.
- R2: When idle, armed and not inhibited, a 0-to-1 transition of vcc_low_i (sampled at a clock edge) sets pull_en_o and busy_o from that edge onward.
- R3: At most one autostore attempt occurs per high period of vcc_low_i. The trigger rearms only after vcc_low_i has been sampled low. It is not armed out of reset.
- R4: With inhibit_i high, a rise of vcc_low_i starts no store, while an explicit request still does.
- R5: A req_i pulse sampled while vcc_low_i is high is ignored: busy_o and pull_en_o stay low.
- R6: A store that is not aborted keeps pull_en_o high for exactly PULL_CYCLES cycles.
- R7: SETTLE_CYCLES cycles after the pull-down starts, the controller checks the synchronized line level. If the line is high, abort_o pulses for one cycle and pull_en_o and busy_o drop in that same cycle.
- R8: If the synchronized line is low at the check, store_start_o pulses for one cycle. pull_en_o stays high at that point.
- R9: After a successful check, busy_o stays high until both the pull window has ended and done_i has been seen. A done_i seen during the window is remembered.
- R10: Requests of either kind that arrive while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_low_i | input | 1 | Supply is below the switch threshold |
| inhibit_i | input | 1 | Autostore inhibit strap |
| req_i | input | 1 | Explicit store request pulse |
| hs_line_i | input | 1 | Sensed level of the shared handshake line |
| done_i | input | 1 | Array copy engine reports completion |
| pull_en_o | output | 1 | Enable for the handshake-line pull-down |
| store_start_o | output | 1 | One-cycle pulse: store confirmed |
| abort_o | output | 1 | One-cycle pulse: store vetoed |
| busy_o | output | 1 | Store attempt in progress |

## Verification
The assertions check these properties on every cycle:
- the start and abort pulses never coincide and each lasts one cycle;
- the pull-down is never on without busy;
- an abort always follows a high synchronized line and leaves the controller idle;
- a store that began while the supply was low never began under inhibit;
- the trigger fires once per crossing.

Only the bench scenarios can show that the pull window has its exact length and that the settle delay is counted correctly. The same holds for a done that arrives early being remembered, for the trigger rearming after the supply recovers, and for requests being dropped while low voltage holds or while busy. To show these, a behavioural model is compared with the outputs on every clock.

// File: rtl/shc_pkg.sv
package shc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DRIVE  = 2'd2,
        ST_WAIT   = 2'd3
    } shc_state_e;
endpackage

// File: rtl/shc_sync2.sv
module shc_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: RESET_VAL, s2: RESET_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q.s2;
endmodule

// File: rtl/shc_arm.sv
module shc_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low_i,
    input  logic inhibit_i,
    input  logic idle_i,
    output logic trig_o
);
    logic armed_d, armed_q;

    always_comb begin
        // The trigger rearms only once the supply flag is seen low.
        armed_d = !vcc_low_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign trig_o = vcc_low_i && armed_q && !inhibit_i && idle_i;

    // R3: a single crossing cannot fire twice in a row
    p_single_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
    // R4: inhibit suppresses the decay trigger
    p_inhibit_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |-> !trig_o);
endmodule

// File: rtl/store_handshake_ctrl.sv
module store_handshake_ctrl #(
    parameter int PULL_CYCLES   = 2000,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low_i,
    input  logic inhibit_i,
    input  logic req_i,
    input  logic hs_line_i,
    input  logic done_i,
    output logic pull_en_o,
    output logic store_start_o,
    output logic abort_o,
    output logic busy_o
);
    import shc_pkg::*;

    localparam int CW = $clog2(PULL_CYCLES + 1);
    localparam logic [CW-1:0] CHECK_AT = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] WIN_END  = CW'(PULL_CYCLES - 1);

    typedef struct packed {
        shc_state_e     st;
        logic [CW-1:0]  cnt;
        logic           done_seen;
        logic           start;
        logic           abort;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  line_sync;
    logic  auto_trig;
    logic  idle;
    logic  req_ok;

    assign idle = (ctl_q.st == ST_IDLE);

    shc_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hs_line_i),
        .q_o   (line_sync)
    );

    shc_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vcc_low_i (vcc_low_i),
        .inhibit_i (inhibit_i),
        .idle_i    (idle),
        .trig_o    (auto_trig)
    );

    // Explicit requests are refused under low voltage and while busy.
    assign req_ok = req_i && !vcc_low_i && idle;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.abort = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (auto_trig || req_ok) begin
                    ctl_d.st        = ST_SETTLE;
                    ctl_d.cnt       = '0;
                    ctl_d.done_seen = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (ctl_q.cnt == CHECK_AT) begin
                    if (line_sync) begin
                        ctl_d.abort = 1'b1;
                        ctl_d.st    = ST_IDLE;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.start = 1'b1;
                        ctl_d.st    = ST_DRIVE;
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_DRIVE: begin
                if (done_i) begin
                    ctl_d.done_seen = 1'b1;
                end
                if (ctl_q.cnt >= WIN_END) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = (ctl_q.done_seen || done_i) ? ST_IDLE : ST_WAIT;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (done_i) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, done_seen: 1'b0, start: 1'b0, abort: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pull_en_o     = (ctl_q.st == ST_SETTLE) || (ctl_q.st == ST_DRIVE);
    assign busy_o        = !idle;
    assign store_start_o = ctl_q.start;
    assign abort_o       = ctl_q.abort;

    // R7/R8: outcome pulses are exclusive
    p_excl_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_start_o, abort_o}));
    // R8: store-start lasts one cycle and the pull-down is still on
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_start_o |=> !store_start_o);
    p_start_pulling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_start_o |-> pull_en_o);
    // R7: an abort follows a high synchronized line and leaves idle
    p_abort_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(line_sync));
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!pull_en_o && !busy_o));
    // R6: the pull-down is only on during an attempt
    p_pull_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en_o |-> busy_o);
    // R4/R5: a store begun under low voltage came from an uninhibited decay
    p_low_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(vcc_low_i)) |-> !$past(inhibit_i));
endmodule

// File: tb/store_handshake_ctrl_test.sv
module store_handshake_ctrl_test;
    localparam int PULL   = 24;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_low = 1'b0, inhibit = 1'b0, req = 1'b0, done = 1'b0, veto = 1'b0;
    logic hs_line;
    logic pull_en, store_start, abort_p, busy;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    // Open-drain line: pulled low unless an outside driver holds it high.
    assign hs_line = veto ? 1'b1 : !pull_en;

    store_handshake_ctrl #(.PULL_CYCLES(PULL), .SETTLE_CYCLES(SETTLE)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_low_i     (vcc_low),
        .inhibit_i     (inhibit),
        .req_i         (req),
        .hs_line_i     (hs_line),
        .done_i        (done),
        .pull_en_o     (pull_en),
        .store_start_o (store_start),
        .abort_o       (abort_p),
        .busy_o        (busy)
    );

    // Behavioural reference: phase 0 idle, 1 checking, 2 window, 3 awaiting done
    int m_phase = 0, m_elapsed = 0;
    bit m_remember = 0, m_start = 0, m_abort = 0, m_low_prev = 1;
    bit m_line_q[$] = '{1'b1, 1'b1};

    function automatic bit m_pull();
        return (m_phase == 1) || (m_phase == 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_elapsed = 0; m_remember = 0;
            m_start = 0; m_abort = 0; m_low_prev = 1;
            m_line_q = '{1'b1, 1'b1};
        end else begin
            bit seen;
            bit line_now;
            seen = m_line_q[0];
            line_now = veto | !m_pull();
            m_start = 0; m_abort = 0;
            case (m_phase)
                0: if ((vcc_low && !m_low_prev && !inhibit) || (req && !vcc_low)) begin
                       m_phase = 1; m_elapsed = 0; m_remember = 0;
                   end
                1: begin
                       m_elapsed++;
                       if (m_elapsed == SETTLE) begin
                           if (seen) begin m_abort = 1; m_phase = 0; end
                           else begin m_start = 1; m_phase = 2; end
                       end
                   end
                2: begin
                       if (done) m_remember = 1;
                       m_elapsed++;
                       if (m_elapsed == PULL) m_phase = m_remember ? 0 : 3;
                   end
                default: if (done) m_phase = 0;
            endcase
            m_low_prev = vcc_low;
            void'(m_line_q.pop_front());
            m_line_q.push_back(line_now);
        end
    end

    always @(negedge clk) begin
        if (rst_n || cycles > 0) begin
            vectors++;
            if ({pull_en, store_start, abort_p, busy} !==
                {m_pull(), m_start, m_abort, (m_phase != 0)}) begin
                fails++;
                $display("FAIL %s cycle %0d: pull/start/abort/busy got %b%b%b%b expected %b%b%b%b",
                         cur_req, cycles, pull_en, store_start, abort_p, busy,
                         m_pull(), m_start, m_abort, (m_phase != 0));
            end
        end
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(3);

        cur_req = "R8_R6_R9_done_early";
        pulse_req();
        wait_cycles(10);
        pulse_done();
        wait_cycles(PULL + 5);

        cur_req = "R9_done_late";
        pulse_req();
        wait_cycles(PULL + 6);
        pulse_done();
        wait_cycles(4);

        cur_req = "R10_req_while_busy";
        pulse_req();
        wait_cycles(2);
        pulse_req();
        wait_cycles(PULL);
        pulse_done();
        wait_cycles(4);

        cur_req = "R7_veto_abort";
        veto = 1'b1;
        pulse_req();
        wait_cycles(SETTLE + 4);
        veto = 1'b0;
        wait_cycles(3);

        cur_req = "R2_autostore";
        @(negedge clk); vcc_low = 1'b1;
        wait_cycles(PULL + 4);
        pulse_done();
        wait_cycles(3);

        cur_req = "R3_no_retrigger_R5_req_low";
        pulse_req();
        wait_cycles(10);
        @(negedge clk); vcc_low = 1'b0;
        wait_cycles(3);

        cur_req = "R3_rearm";
        @(negedge clk); vcc_low = 1'b1;
        wait_cycles(PULL + 2);
        pulse_done();
        @(negedge clk); vcc_low = 1'b0;
        wait_cycles(3);

        cur_req = "R4_inhibit";
        inhibit = 1'b1;
        @(negedge clk); vcc_low = 1'b1;
        wait_cycles(10);
        @(negedge clk); vcc_low = 1'b0;
        wait_cycles(2);
        pulse_req();
        wait_cycles(PULL + 2);
        pulse_done();
        inhibit = 1'b0;
        wait_cycles(3);

        cur_req = "R7_veto_autostore";
        veto = 1'b1;
        @(negedge clk); vcc_low = 1'b1;
        wait_cycles(SETTLE + 6);
        veto = 1'b0;
        @(negedge clk); vcc_low = 1'b0;
        wait_cycles(4);

        cur_req = "R1_reset_midstore";
        pulse_req();
        wait_cycles(3);
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule